// File: doc/BRIEF.md
# Accumulator-Driven Step Pulse Profile Generator

This block produces step and direction signals for a stepper motor driver from a short queue of motion segments. Each segment the host writes carries four things: a signed starting rate, a signed acceleration, a step count and an optional mode value. The host fills the queue, then pulses a run strobe. Execution then continues with no software involvement until the queue is empty. A done flag reports when the run has ended and nothing is left in the queue.

An internal divider turns the system clock into a slower update tick. On each tick of an active segment, two things happen together. The angle accumulator adds the current rate. The rate accumulator adds the acceleration. The angle accumulator holds a fraction of one step. When it wraps past one step or below zero, the block emits a step pulse. The direction output then holds the sign of the rate that produced that step. A chain of segments therefore gives ramp-up, cruise and ramp-down profiles.

The rate carries fewer fractional bits than the acceleration. The angle accumulator's precision lies between the two, and operands are shifted to that precision before they are added. Parameters can remove the direction output and the mode output, and can add a registered copy of an error input from the driver.

Top module: `step_profile_gen`

## Requirements
- R1: The update tick recurs every DIV clock cycles. DIV is TICK_COUNT when USE_COUNT=1, and CLK_HZ/TICK_HZ otherwise.
- R2: Loading a segment sets the rate accumulator to the starting rate. The starting rate is signed, with RATE_FRAC fractional bits in units of steps per tick. On every later tick of that segment, the rate accumulator adds the acceleration, which is signed with ACCEL_FRAC fractional bits.
- R3: On each tick of an active segment, the angle accumulator (ANGLE_FRAC fractional bits, one step = 2^ANGLE_FRAC) adds the pre-tick rate. When the sum reaches one step or falls below zero, step_o is high for exactly one clock.
- R4: dir_o holds the sign of the rate that caused the latest step. It is 0 for an upward wrap and 1 for a downward wrap. When HAS_DIR=0, dir_o is held at 0.
- R5: The queue holds up to DEPTH records. A write while the queue is full is dropped.
- R6: Stepping begins only after a run strobe. A strobe that arrives while the queue is empty, or while a run is in progress, has no effect. In particular, it does not disturb the step timing.
- R7: A segment ends after its programmed number of steps. The next record loads on the following tick. When the queue is empty, stepping stops and done_o goes to 1.
- R8: A segment with a step count of 0 completes without emitting any step.
- R9: mode_o shows the mode field of the segment most recently loaded. When MODE_W=0, mode_o is 0.
- R10: When HAS_FAULT=1, fault_o equals drv_fault_i delayed by one clock. Otherwise fault_o is 0.
- R11: After reset, done_o=1 and step_o, dir_o, mode_o and fault_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Push one segment record into the queue |
| wr_rate_i | input | RATE_FRAC+1 | Signed starting rate, steps per tick |
| wr_accel_i | input | ACCEL_W | Signed acceleration per tick |
| wr_count_i | input | COUNT_W | Steps in the segment |
| wr_mode_i | input | max(MODE_W,1) | Mode value for the segment |
| run_i | input | 1 | Start strobe |
| done_o | output | 1 | Idle with an empty queue |
| step_o | output | 1 | One-clock step strobe |
| dir_o | output | 1 | Direction of the latest step |
| mode_o | output | max(MODE_W,1) | Mode of the current segment |
| drv_fault_i | input | 1 | Error signal from the driver |
| fault_o | output | 1 | Registered copy of the driver error |

## Verification
The assertions take three things for granted about the host:

- It keeps the accumulated rate magnitude below one step per tick, so at most one wrap occurs per tick.
- It programs ACCEL_FRAC larger than RATE_FRAC.
- It places ANGLE_FRAC between those two.

Under these assumptions, each step's direction agrees with the way the angle moved. Every stimulus in the bench uses rates of at most half a step per tick and small accelerations, so the accumulated rate never comes near the limit during a segment.

// File: rtl/step_profile_pkg.sv
package step_profile_pkg;
   typedef enum logic [1:0] {
      SP_IDLE  = 2'd0,
      SP_FETCH = 2'd1,
      SP_MOVE  = 2'd2
   } sp_state_e;
endpackage

// File: rtl/step_tick_div.sv
module step_tick_div #(
   parameter int DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV <= 1) begin : g_passthru
         assign tick_o = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(DIV - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick_o = (cnt_q == CW'(DIV - 1));

         AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o) else $error("tick spacing"); // R1
      end
   endgenerate
endmodule

// File: rtl/step_seg_fifo.sv
module step_seg_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic             empty_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
   logic [NW-1:0]    fill_q;
   logic             full, do_push, do_pop;

   assign full    = (fill_q == NW'(DEPTH));
   assign empty_o = (fill_q == '0);
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && !empty_o;
   assign head_o  = mem_q[rd_ptr_q];

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem_q[wr_ptr_q] <= data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         fill_q   <= '0;
      end else begin
         if (do_push) wr_ptr_q <= bump(wr_ptr_q);
         if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
         case ({do_push, do_pop})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= NW'(DEPTH)) else $error("fill above depth"); // R5
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_i && !pop_i) |=> $stable(wr_ptr_q)) else $error("write into full queue"); // R5
endmodule

// File: rtl/step_motion_core.sv
module step_motion_core
   import step_profile_pkg::*;
#(
   parameter int RATE_FRAC  = 8,
   parameter int ACCEL_FRAC = 12,
   parameter int ANGLE_FRAC = 10,
   parameter int ACCEL_W    = 8,
   parameter int COUNT_W    = 8,
   parameter int MODE_PW    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               run_i,
   input  logic               q_empty_i,
   input  logic [RATE_FRAC:0] hd_rate_i,
   input  logic [ACCEL_W-1:0] hd_accel_i,
   input  logic [COUNT_W-1:0] hd_count_i,
   input  logic [MODE_PW-1:0] hd_mode_i,
   output logic               pop_o,
   output logic               idle_o,
   output logic               step_o,
   output logic               sign_o,
   output logic [MODE_PW-1:0] mode_o
);
   localparam int RACC_W = ACCEL_FRAC + 2;
   localparam int SH_R   = ACCEL_FRAC - RATE_FRAC;
   localparam int SH_A   = ACCEL_FRAC - ANGLE_FRAC;
   localparam int SUM_W  = ANGLE_FRAC + 2;

   sp_state_e                 state_q;
   logic signed [RACC_W-1:0]  rate_q, accel_q, rate_ld, rate_shift;
   logic signed [SUM_W-1:0]   rate_al, sum;
   logic [ANGLE_FRAC-1:0]     angle_q;
   logic [COUNT_W-1:0]        target_q, taken_q, taken_nx;
   logic                      wrap_up, wrap_dn, step_q, sign_q;
   logic [MODE_PW-1:0]        mode_q;

   assign rate_ld    = RACC_W'($signed(hd_rate_i)) <<< SH_R;
   assign rate_shift = rate_q >>> SH_A;
   assign rate_al    = rate_shift[SUM_W-1:0];
   assign sum        = $signed({2'b00, angle_q}) + rate_al;
   assign wrap_dn    = sum[SUM_W-1];
   assign wrap_up    = !sum[SUM_W-1] && sum[ANGLE_FRAC];
   assign taken_nx   = taken_q + 1'b1;
   assign pop_o      = (state_q == SP_FETCH) && tick_i && !q_empty_i;
   assign idle_o     = (state_q == SP_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SP_IDLE;
         rate_q   <= '0;
         accel_q  <= '0;
         angle_q  <= '0;
         target_q <= '0;
         taken_q  <= '0;
         step_q   <= 1'b0;
         sign_q   <= 1'b0;
         mode_q   <= '0;
      end else begin
         step_q <= 1'b0;
         case (state_q)
            SP_IDLE: begin
               if (run_i && !q_empty_i) begin
                  state_q <= SP_FETCH;
                  angle_q <= '0;
               end
            end
            SP_FETCH: begin
               if (tick_i) begin
                  if (q_empty_i) begin
                     state_q <= SP_IDLE;
                  end else begin
                     rate_q   <= rate_ld;
                     accel_q  <= RACC_W'($signed(hd_accel_i));
                     target_q <= hd_count_i;
                     taken_q  <= '0;
                     mode_q   <= hd_mode_i;
                     state_q  <= (hd_count_i == '0) ? SP_FETCH : SP_MOVE;
                  end
               end
            end
            SP_MOVE: begin
               if (tick_i) begin
                  angle_q <= sum[ANGLE_FRAC-1:0];
                  rate_q  <= rate_q + accel_q;
                  if (wrap_up || wrap_dn) begin
                     step_q  <= 1'b1;
                     sign_q  <= wrap_dn;
                     taken_q <= taken_nx;
                     if (taken_nx == target_q) state_q <= SP_FETCH;
                  end
               end
            end
            default: state_q <= SP_IDLE;
         endcase
      end
   end

   assign step_o = step_q;
   assign sign_o = sign_q;
   assign mode_o = mode_q;

   AST_RATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SP_MOVE) |-> (rate_q[RACC_W-1] == rate_q[RACC_W-2])) else $error("rate out of range"); // R2
   AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |-> (sign_q ? (angle_q > $past(angle_q)) : (angle_q < $past(angle_q)))) else $error("dir vs wrap"); // R4
   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SP_MOVE) |-> (taken_q < target_q)) else $error("step count overrun"); // R7
   AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_o && hd_count_i == '0) |=> !step_q) else $error("step on empty segment"); // R8
   AST_RUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SP_IDLE && run_i && !tick_i) |=> $stable(angle_q)) else $error("run restarted"); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SP_IDLE) |=> !step_q) else $error("step while idle"); // R7
endmodule

// File: rtl/step_profile_gen.sv
module step_profile_gen #(
   parameter int CLK_HZ     = 125_000_000,
   parameter int TICK_HZ    = 1_000_000,
   parameter bit USE_COUNT  = 1'b1,
   parameter int TICK_COUNT = 3,
   parameter int RATE_FRAC  = 8,
   parameter int ACCEL_FRAC = 12,
   parameter int ANGLE_FRAC = 10,
   parameter int ACCEL_W    = 8,
   parameter int COUNT_W    = 8,
   parameter int MODE_W     = 2,
   parameter int DEPTH      = 4,
   parameter bit HAS_DIR    = 1'b1,
   parameter bit HAS_FAULT  = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en_i,
   input  logic [RATE_FRAC:0]                  wr_rate_i,
   input  logic [ACCEL_W-1:0]                  wr_accel_i,
   input  logic [COUNT_W-1:0]                  wr_count_i,
   input  logic [((MODE_W > 0) ? MODE_W : 1)-1:0] wr_mode_i,
   input  logic                                run_i,
   output logic                                done_o,
   output logic                                step_o,
   output logic                                dir_o,
   output logic [((MODE_W > 0) ? MODE_W : 1)-1:0] mode_o,
   input  logic                                drv_fault_i,
   output logic                                fault_o
);
   localparam int DIV     = USE_COUNT ? TICK_COUNT : (CLK_HZ / TICK_HZ);
   localparam int MODE_PW = (MODE_W > 0) ? MODE_W : 1;
   localparam int RATE_W  = RATE_FRAC + 1;
   localparam int REC_W   = MODE_PW + COUNT_W + ACCEL_W + RATE_W;

   generate
      if (RATE_FRAC >= ACCEL_FRAC) begin : g_bad_res
         $error("RATE_FRAC must be below ACCEL_FRAC");
      end
      if (ANGLE_FRAC < RATE_FRAC || ANGLE_FRAC > ACCEL_FRAC) begin : g_bad_angle
         $error("ANGLE_FRAC must lie between RATE_FRAC and ACCEL_FRAC");
      end
      if (DEPTH < 1 || DIV < 1 || COUNT_W < 1) begin : g_bad_size
         $error("DEPTH, divider and COUNT_W must be positive");
      end
   endgenerate

   logic                tick, pop, q_empty, idle, sign;
   logic [REC_W-1:0]    rec_in, head;
   logic [MODE_PW-1:0]  wr_mode_m, core_mode;

   assign wr_mode_m = (MODE_W > 0) ? wr_mode_i : '0;
   assign rec_in    = {wr_mode_m, wr_count_i, wr_accel_i, wr_rate_i};

   step_tick_div #(.DIV(DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   step_seg_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (wr_en_i),
      .data_i  (rec_in),
      .pop_i   (pop),
      .head_o  (head),
      .empty_o (q_empty)
   );

   step_motion_core #(
      .RATE_FRAC  (RATE_FRAC),
      .ACCEL_FRAC (ACCEL_FRAC),
      .ANGLE_FRAC (ANGLE_FRAC),
      .ACCEL_W    (ACCEL_W),
      .COUNT_W    (COUNT_W),
      .MODE_PW    (MODE_PW)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .run_i      (run_i),
      .q_empty_i  (q_empty),
      .hd_rate_i  (head[RATE_W-1:0]),
      .hd_accel_i (head[RATE_W +: ACCEL_W]),
      .hd_count_i (head[RATE_W+ACCEL_W +: COUNT_W]),
      .hd_mode_i  (head[REC_W-1 -: MODE_PW]),
      .pop_o      (pop),
      .idle_o     (idle),
      .step_o     (step_o),
      .sign_o     (sign),
      .mode_o     (core_mode)
   );

   assign done_o = idle && q_empty;

   generate
      if (HAS_DIR) begin : g_dir
         assign dir_o = sign;
      end else begin : g_nodir
         assign dir_o = 1'b0;
      end

      if (MODE_W > 0) begin : g_mode
         assign mode_o = core_mode;
      end else begin : g_nomode
         assign mode_o = '0;
      end

      if (HAS_FAULT) begin : g_fault
         logic fault_q;
         always_ff @(posedge clk) begin
            if (!rst_n) fault_q <= 1'b0;
            else        fault_q <= drv_fault_i;
         end
         assign fault_o = fault_q;
         AST_FAULT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (fault_o == $past(drv_fault_i))) else $error("fault copy"); // R10
      end else begin : g_nofault
         assign fault_o = 1'b0;
      end

      if (DIV > 1) begin : g_pulse
         AST_STEP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            step_o |=> !step_o) else $error("step wider than one clock"); // R3
      end
   endgenerate

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !run_i) |=> !step_o) else $error("step after done"); // R7
endmodule

// File: tb/step_profile_gen_bench.sv
`timescale 1ns/1ps
module step_profile_gen_bench;
   localparam int DIV = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_rate = '0;
   logic [7:0] wr_accel = '0;
   logic [7:0] wr_count = '0;
   logic [1:0] wr_mode = '0;
   logic       run = 1'b0;
   logic       fault_in = 1'b0;
   logic       done, step, dir, fault_out;
   logic [1:0] mode;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int nstep = 0;
   int st_t   [32];
   logic st_dir  [32];
   logic [1:0] st_mode [32];

   always #4 clk = ~clk;

   step_profile_gen u_step_profile_gen (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_rate_i(wr_rate),
      .wr_accel_i(wr_accel), .wr_count_i(wr_count), .wr_mode_i(wr_mode),
      .run_i(run), .done_o(done), .step_o(step), .dir_o(dir), .mode_o(mode),
      .drv_fault_i(fault_in), .fault_o(fault_out)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (step) begin
         if (nstep < 32) begin
            st_t[nstep]    = cyc;
            st_dir[nstep]  = dir;
            st_mode[nstep] = mode;
         end
         nstep = nstep + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(input logic [8:0] r, input logic [7:0] a, input logic [7:0] c, input logic [1:0] m);
      @(negedge clk);
      wr_en = 1'b1; wr_rate = r; wr_accel = a; wr_count = c; wr_mode = m;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic go();
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      run = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(done == 1'b1, req, int'(done), 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      check(done == 1'b1, "R11 done", int'(done), 1);
      check(step == 1'b0, "R11 step", int'(step), 0);
      check(dir == 1'b0, "R11 dir", int'(dir), 0);
      check(mode == 2'd0, "R11 mode", int'(mode), 0);
      check(fault_out == 1'b0, "R11 fault", int'(fault_out), 0);
   endtask

   // R3/R1: rate 0.25 step per tick -> one step every 4 ticks = 12 clocks
   task automatic t_forward();
      nstep = 0;
      put(9'h040, 8'd0, 8'd5, 2'd2);
      check(done == 1'b0, "R7 done low when queued", int'(done), 0);
      go();
      wait_done("R7 forward done");
      check(nstep == 5, "R7 forward count", nstep, 5);
      for (int i = 1; i < 5; i++)
         check(st_t[i] - st_t[i-1] == 4 * DIV, "R1 R3 forward interval", st_t[i] - st_t[i-1], 4 * DIV);
      for (int i = 0; i < 5; i++) begin
         check(st_dir[i] == 1'b0, "R4 forward dir", int'(st_dir[i]), 0);
         check(st_mode[i] == 2'd2, "R9 mode", int'(st_mode[i]), 2);
      end
   endtask

   // R4: rate -0.25 wraps downward
   task automatic t_reverse();
      nstep = 0;
      put(9'h1C0, 8'd0, 8'd3, 2'd1);
      go();
      wait_done("R7 reverse done");
      check(nstep == 3, "R7 reverse count", nstep, 3);
      for (int i = 0; i < 3; i++)
         check(st_dir[i] == 1'b1, "R4 reverse dir", int'(st_dir[i]), 1);
      for (int i = 1; i < 3; i++)
         check(st_t[i] - st_t[i-1] == 4 * DIV, "R3 reverse interval", st_t[i] - st_t[i-1], 4 * DIV);
      check(mode == 2'd1, "R9 mode held", int'(mode), 1);
   endtask

   // R8: empty segment skipped, following segment runs
   task automatic t_zero();
      nstep = 0;
      put(9'h080, 8'd0, 8'd0, 2'd0);
      put(9'h080, 8'd0, 8'd2, 2'd0);
      go();
      wait_done("R8 done");
      check(nstep == 2, "R8 zero-count segment", nstep, 2);
   endtask

   // R2: rate from 0 with acceleration -> shrinking intervals
   task automatic t_accel();
      nstep = 0;
      put(9'h000, 8'd16, 8'd4, 2'd0);
      go();
      wait_done("R2 done");
      check(nstep == 4, "R2 accel count", nstep, 4);
      for (int i = 2; i < 4; i++)
         check(st_t[i] - st_t[i-1] < st_t[i-1] - st_t[i-2], "R2 ramp shortens",
               st_t[i] - st_t[i-1], st_t[i-1] - st_t[i-2]);
   endtask

   // R5: fifth write into a full queue of four is dropped
   task automatic t_full();
      nstep = 0;
      for (int i = 0; i < 5; i++) put(9'h080, 8'd0, 8'd1, 2'd0);
      go();
      wait_done("R5 done");
      check(nstep == 4, "R5 full write dropped", nstep, 4);
   endtask

   // R6: run with empty queue does nothing
   task automatic t_empty_run();
      nstep = 0;
      go();
      repeat (30) @(negedge clk);
      check(nstep == 0, "R6 empty run steps", nstep, 0);
      check(done == 1'b1, "R6 empty run done", int'(done), 1);
   endtask

   // R6: rate 3/8 gives intervals 3,2,3 ticks; a strobe mid-run keeps them
   task automatic t_rerun();
      nstep = 0;
      put(9'h060, 8'd0, 8'd4, 2'd0);
      go();
      while (nstep < 2) @(negedge clk);
      go();
      wait_done("R6 rerun done");
      check(nstep == 4, "R6 rerun count", nstep, 4);
      check(st_t[1] - st_t[0] == 3 * DIV, "R6 interval 1", st_t[1] - st_t[0], 3 * DIV);
      check(st_t[2] - st_t[1] == 2 * DIV, "R6 interval 2", st_t[2] - st_t[1], 2 * DIV);
      check(st_t[3] - st_t[2] == 3 * DIV, "R6 interval 3", st_t[3] - st_t[2], 3 * DIV);
   endtask

   // R10: fault copied with one clock of delay
   task automatic t_fault();
      @(negedge clk);
      fault_in = 1'b1;
      check(fault_out == 1'b0, "R10 fault before edge", int'(fault_out), 0);
      @(negedge clk);
      check(fault_out == 1'b1, "R10 fault set", int'(fault_out), 1);
      fault_in = 1'b0;
      @(negedge clk);
      check(fault_out == 1'b0, "R10 fault clear", int'(fault_out), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_forward();
      t_reverse();
      t_zero();
      t_accel();
      t_full();
      t_empty_run();
      t_rerun();
      t_fault();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule